// File: doc/BRIEF.md
# Color Affine Clamp Pixel Stage

This block is one stage of a streaming color pipeline. It takes one packed RGB pixel per clock. It turns each 8-bit channel into a signed fixed-point fraction and hands the resulting triple to an external warp engine, which has a long latency. At the same moment it parks the raw pixel in a bypass FIFO. When the warp engine returns a result triple, the stage pops the matching bypass entry. It then adds a per-channel affine color term drawn from a 4x3 coefficient table, saturates each channel to an 8-bit code and emits the repacked pixel.

The coefficient table is written through a plain write port while no frame is in flight. The bypass FIFO decouples the two branches of the split. Its depth must exceed the warp engine's latency, or the stream stalls. When that FIFO fills, the stage stops taking input rather than losing a pixel.

The output side is a small state machine with two states. In `OUT_IDLE` the output register holds nothing. In `OUT_BUSY` it holds a pixel that the consumer has not yet taken. The transitions are as follows. A load moves the machine from `OUT_IDLE` to `OUT_BUSY` when the sum stage hands over a pixel. A stream keeps it in `OUT_BUSY` when the consumer takes the pixel and a new one arrives in the same cycle. A drain returns it to `OUT_IDLE` when the consumer takes the pixel and nothing follows. A stall keeps it in `OUT_BUSY` while `out_ready` is low.

Top module: `color_affine_stage`

## Requirements
- R1: Input and output pixels carry red in bits 23:16, green in bits 15:8 and blue in bits 7:0. With a diagonal table of 256.0 (word 0x0100_0000), zero offsets and a warp result equal to the request, each output pixel equals its input pixel.
- R2: On the warp request each channel is a signed 32-bit word with 16 fraction bits holding channel/256, which is the 8-bit value shifted left by 8. Red sits in bits 95:64, green in bits 63:32 and blue in bits 31:0. The response uses the same layout.
- R3: Coefficient words are signed 32-bit with 16 fraction bits, addressed by a row (0 constant, 1 red, 2 green, 3 blue) and a column (0 red, 1 green, 2 blue). Output channel c is the sum of warp[c], coef[0][c] and norm_k*coef[k+1][c] over the three input channels k. Each product is floored to 16 fraction bits before it is summed.
- R4: A channel sum below zero produces the code 0.
- R5: A channel sum at or above 255.0 produces the code 255. A sum in between yields its integer part, with the fraction truncated.
- R6: Output pixels leave in the same order as input pixels entered, each joined with its own warp result.
- R7: With BYP_DEPTH pixels waiting in the bypass FIFO, `in_ready` and `warp_req_valid` are low and no pixel is accepted until a warp result drains an entry.
- R8: With the warp engine, its latency and the consumer all keeping pace, one pixel is accepted and one pixel emitted on every clock.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pixel` holds its value on the next clock.
- R10: After reset `out_valid` and `warp_rsp_ready` are low, and `in_ready` follows `warp_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_row | input | 2 | Coefficient row (0 constant, 1..3 input channel) |
| coef_col | input | 2 | Coefficient column (output channel) |
| coef_wdata | input | 32 | Coefficient word, signed 16 fraction bits |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 24 | Packed input pixel |
| warp_req_valid | output | 1 | Normalized triple offered to the warp engine |
| warp_req_ready | input | 1 | Warp engine takes the triple |
| warp_req_tri | output | 96 | Normalized triple |
| warp_rsp_valid | input | 1 | Warp result available |
| warp_rsp_ready | output | 1 | Stage takes the warp result |
| warp_rsp_tri | input | 96 | Warp result triple |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pixel | output | 24 | Packed output pixel |

## Verification
The bench builds the stage with BYP_DEPTH set to 4, and its warp model returns results two cycles after a request. At that depth the full-FIFO stall appears after only four pixels while the warp results are held back. The same two-cycle latency still leaves room to show that the stage takes one pixel per clock without stalling. Random ready patterns on the warp request and the output interleave backpressure with join events, so that ordering and output holding are exercised.

// File: rtl/cas_pkg.sv
`timescale 1ns/1ps
package cas_pkg;
    localparam int CH        = 3;
    localparam int CH_W      = 8;
    localparam int FX_W      = 32;
    localparam int FRAC      = 16;
    localparam int COEF_ROWS = CH + 1;
    localparam int ACC_W     = 64;
    localparam int PIX_W     = CH * CH_W;
    localparam int TRI_W     = CH * FX_W;
    localparam int ROW_W     = $clog2(COEF_ROWS);
    localparam int COL_W     = $clog2(CH);
    localparam int TBL_W     = COEF_ROWS * CH * FX_W;

    typedef logic signed [FX_W-1:0]  fx_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [0:0] {
        OUT_IDLE = 1'b0,
        OUT_BUSY = 1'b1
    } out_state_e;

    // 8-bit code to a fraction of 256 in fixed point
    function automatic fx_t norm_chan(input logic [CH_W-1:0] code);
        return fx_t'(code) << (FRAC - CH_W);
    endfunction

    // product of two fixed-point words, floored back to FRAC fraction bits
    function automatic acc_t fx_mul(input fx_t a, input fx_t b);
        acc_t full;
        full = acc_t'(a) * acc_t'(b);
        return full >>> FRAC;
    endfunction

    // saturate to [0, 2^CH_W - 1] and truncate the fraction
    function automatic logic [CH_W-1:0] sat_code(input acc_t s);
        acc_t top;
        top = acc_t'((1 << CH_W) - 1) <<< FRAC;
        if (s < 0)
            return '0;
        else if (s >= top)
            return '1;
        else
            return s[FRAC +: CH_W];
    endfunction
endpackage

// File: rtl/cas_coef_table.sv
`timescale 1ns/1ps
module cas_coef_table
    import cas_pkg::*;
#(
    parameter int ROWS = COEF_ROWS,
    parameter int COLS = CH,
    parameter int W    = FX_W,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RW-1:0]           wr_row,
    input  logic [CW-1:0]           wr_col,
    input  logic [W-1:0]            wr_data,
    output logic [ROWS*COLS*W-1:0]  table_flat
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (wr_en && wr_row == RW'(r) && wr_col == CW'(c))
                    cell_q <= wr_data;
            end
            assign table_flat[(r*COLS + c)*W +: W] = cell_q;
        end
    end
endmodule

// File: rtl/cas_bypass_fifo.sv
`timescale 1ns/1ps
module cas_bypass_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rd_data = store[rd_ptr];
    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7
    fill_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> fill == CW'($past(fill) + 1'b1));
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cas_affine_join.sv
`timescale 1ns/1ps
module cas_affine_join
    import cas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TBL_W-1:0] coef_flat,
    input  logic             warp_valid,
    output logic             warp_ready,
    input  logic [TRI_W-1:0] warp_tri,
    input  logic             byp_empty,
    output logic             byp_pop,
    input  logic [PIX_W-1:0] byp_pixel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pixel
);
    out_state_e state_q, state_d;
    logic       s1_v;
    logic       s1_free, s2_take, join_fire;
    acc_t       sum_d [CH];
    acc_t       sum_q [CH];

    // handshake glue between the two branches and the sum stage
    always_comb begin
        s2_take    = s1_v && (state_q == OUT_IDLE || out_ready);
        s1_free    = !s1_v || s2_take;
        warp_ready = !byp_empty && s1_free;
        join_fire  = warp_valid && warp_ready;
        byp_pop    = join_fire;
    end

    // affine term plus warp result, per output channel
    always_comb begin
        for (int c = 0; c < CH; c++) begin
            sum_d[c] = acc_t'(fx_t'(warp_tri[(CH-1-c)*FX_W +: FX_W]))
                     + acc_t'(fx_t'(coef_flat[c*FX_W +: FX_W]));
            for (int k = 0; k < CH; k++) begin
                sum_d[c] = sum_d[c]
                         + fx_mul(norm_chan(byp_pixel[(CH-1-k)*CH_W +: CH_W]),
                                  fx_t'(coef_flat[((k+1)*CH + c)*FX_W +: FX_W]));
            end
        end
    end

    // stage one: joined sums
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_v <= 1'b0;
        else
            s1_v <= join_fire || (s1_v && !s2_take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++) sum_q[c] <= '0;
        end else if (join_fire) begin
            for (int c = 0; c < CH; c++) sum_q[c] <= sum_d[c];
        end
    end

    // output state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OUT_IDLE;
        else
            state_q <= state_d;
    end

    // output next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: state_d = s2_take ? OUT_BUSY : OUT_IDLE;
            OUT_BUSY: begin
                if (out_ready)
                    state_d = s2_take ? OUT_BUSY : OUT_IDLE;
                else
                    state_d = OUT_BUSY;
            end
            default:  state_d = OUT_IDLE;
        endcase
    end

    // output data: saturate and repack on stage-two transfer
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_pixel <= '0;
        else if (s2_take) begin
            for (int c = 0; c < CH; c++)
                out_pixel[(CH-1-c)*CH_W +: CH_W] <= sat_code(sum_q[c]);
        end
    end

    assign out_valid = (state_q == OUT_BUSY);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));
    // R8
    stream_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && (!out_valid || out_ready)) |=> out_valid);
    // R10
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: rtl/color_affine_stage.sv
`timescale 1ns/1ps
module color_affine_stage
    import cas_pkg::*;
#(
    parameter int BYP_DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coef_we,
    input  logic [ROW_W-1:0] coef_row,
    input  logic [COL_W-1:0] coef_col,
    input  logic [FX_W-1:0]  coef_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pixel,
    output logic             warp_req_valid,
    input  logic             warp_req_ready,
    output logic [TRI_W-1:0] warp_req_tri,
    input  logic             warp_rsp_valid,
    output logic             warp_rsp_ready,
    input  logic [TRI_W-1:0] warp_rsp_tri,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pixel
);
    logic [TBL_W-1:0] coef_flat;
    logic             byp_full, byp_empty, byp_pop, byp_push;
    logic [PIX_W-1:0] byp_pixel;

    cas_coef_table u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (coef_we),
        .wr_row     (coef_row),
        .wr_col     (coef_col),
        .wr_data    (coef_wdata),
        .table_flat (coef_flat)
    );

    // split: one copy to the warp engine, one to the bypass FIFO
    assign warp_req_valid = in_valid && !byp_full;
    assign in_ready       = warp_req_ready && !byp_full;
    assign byp_push       = in_valid && in_ready;

    for (genvar c = 0; c < CH; c++) begin : g_norm
        assign warp_req_tri[(CH-1-c)*FX_W +: FX_W] =
            norm_chan(in_pixel[(CH-1-c)*CH_W +: CH_W]);
    end

    cas_bypass_fifo #(.DEPTH(BYP_DEPTH), .W(PIX_W)) u_bypass (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (byp_push),
        .wr_data (in_pixel),
        .pop     (byp_pop),
        .rd_data (byp_pixel),
        .full    (byp_full),
        .empty   (byp_empty)
    );

    cas_affine_join u_join (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_flat  (coef_flat),
        .warp_valid (warp_rsp_valid),
        .warp_ready (warp_rsp_ready),
        .warp_tri   (warp_rsp_tri),
        .byp_empty  (byp_empty),
        .byp_pop    (byp_pop),
        .byp_pixel  (byp_pixel),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_pixel  (out_pixel)
    );

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !warp_rsp_ready);
endmodule

// File: tb/color_affine_stage_test.sv
`timescale 1ns/1ps
module color_affine_stage_test;
    localparam int DEPTH = 4;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [1:0]  coef_row = '0, coef_col = '0;
    logic [31:0] coef_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pixel = '0;
    logic        warp_req_valid;
    logic        warp_req_ready = 1'b1;
    logic [95:0] warp_req_tri;
    logic        warp_rsp_valid = 1'b0;
    logic        warp_rsp_ready;
    logic [95:0] warp_rsp_tri = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pixel;

    color_affine_stage #(.BYP_DEPTH(DEPTH)) uut (.*);

    always #2 clk = ~clk;

    int          n_chk = 0, n_fail = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    string       cur_tag = "R1";
    int          coef_m [4][3];
    int          woff [3];
    bit          warp_hold = 1'b0, warp_rand = 1'b0, out_rand = 1'b0;
    logic [23:0] exp_q [$];
    int          wstamp_q [$];
    logic [95:0] wdata_q [$];
    int          first_acc = -1, last_acc = 0;
    int          last_out = -10, streak = 0, max_streak = 0;
    bit          hold_prev = 1'b0;
    logic [23:0] hold_data = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_chan(input int c, input logic [23:0] px);
        longint s, top;
        longint n [3];
        for (int k = 0; k < 3; k++) n[k] = longint'(px[(2-k)*8 +: 8]) * 256;
        s = n[c] + longint'(woff[c]) + longint'(coef_m[0][c]);
        for (int k = 0; k < 3; k++) s = s + ((n[k] * longint'(coef_m[k+1][c])) >>> 16);
        top = 255 * 65536;
        if (s < 0) return 8'd0;
        if (s >= top) return 8'd255;
        return 8'(s >>> 16);
    endfunction

    function automatic logic [23:0] ref_pixel(input logic [23:0] px);
        return {ref_chan(0, px), ref_chan(1, px), ref_chan(2, px)};
    endfunction

    // warp engine model
    always begin
        @(negedge clk);
        warp_req_ready = warp_rand ? 1'($urandom % 2) : 1'b1;
        if (!warp_hold && wstamp_q.size() > 0 && cyc >= wstamp_q[0] + LAT) begin
            warp_rsp_valid = 1'b1;
            warp_rsp_tri   = wdata_q[0];
        end else begin
            warp_rsp_valid = 1'b0;
        end
        #1;
        if (rst_n && warp_req_valid && warp_req_ready) begin
            logic [95:0] nexp, rsp;
            for (int c = 0; c < 3; c++) begin
                nexp[(2-c)*32 +: 32] = {16'h0, in_pixel[(2-c)*8 +: 8], 8'h0};
                rsp[(2-c)*32 +: 32]  = 32'(int'(in_pixel[(2-c)*8 +: 8]) * 256 + woff[c]);
            end
            // R2: normalized request layout
            chk(warp_req_tri == nexp, "R2", warp_req_tri, nexp);
            wstamp_q.push_back(cyc);
            wdata_q.push_back(rsp);
        end
        if (rst_n && warp_rsp_valid && warp_rsp_ready) begin
            void'(wstamp_q.pop_front());
            void'(wdata_q.pop_front());
        end
    end

    // output monitor / scoreboard
    always begin
        @(negedge clk);
        out_ready = out_rand ? 1'($urandom % 2) : 1'b1;
        #1;
        if (rst_n) begin
            if (hold_prev)
                chk(out_valid && out_pixel == hold_data, "R9", {out_valid, out_pixel}, {1'b1, hold_data});
            hold_prev = out_valid && !out_ready;
            hold_data = out_pixel;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, out_pixel, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk(out_pixel == e, cur_tag, out_pixel, e);
                end
                streak = (cyc == last_out + 1) ? streak + 1 : 1;
                last_out = cyc;
                if (streak > max_streak) max_streak = streak;
            end
        end
    end

    task automatic send(input logic [23:0] px);
        bit taken = 1'b0;
        in_valid = 1'b1;
        in_pixel = px;
        while (!taken) begin
            #1;
            if (in_ready) begin
                exp_q.push_back(ref_pixel(px));
                if (first_acc < 0) first_acc = cyc;
                last_acc = cyc;
                taken = 1'b1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic write_coef(input int r, input int c, input int v);
        coef_we = 1'b1; coef_row = 2'(r); coef_col = 2'(c); coef_wdata = 32'(v);
        coef_m[r][c] = v;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic load_table(input int diag, input int konst);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 3; c++)
                write_coef(r, c, (r == 0) ? konst : ((r == c + 1) ? diag : 0));
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || out_valid) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, cur_tag, exp_q.size(), 0);
    endtask

    localparam int ONE256 = 32'h0100_0000;

    initial begin
        for (int c = 0; c < 3; c++) woff[c] = 0;
        for (int r = 0; r < 4; r++) for (int c = 0; c < 3; c++) coef_m[r][c] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(!out_valid, "R10", out_valid, 0);
        chk(!warp_rsp_ready, "R10", warp_rsp_ready, 0);
        chk(in_ready == warp_req_ready, "R10", in_ready, warp_req_ready);
        @(negedge clk);

        // R1: identity pass-through and packing
        cur_tag = "R1";
        load_table(ONE256, 0);
        send(24'h000000); send(24'hFFFFFF); send(24'h123456); send(24'hFF0080);
        for (int i = 0; i < 30; i++) send(24'($urandom));
        drain();

        // R3: random affine mix with random warp offsets and backpressure
        cur_tag = "R3";
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 3; c++)
                write_coef(r, c, int'($urandom_range(0, 128 << 16)) - (64 << 16));
        for (int c = 0; c < 3; c++) woff[c] = int'($urandom_range(0, 64 << 16)) - (32 << 16);
        warp_rand = 1'b1; out_rand = 1'b1;
        for (int i = 0; i < 60; i++) send(24'($urandom));
        drain();
        warp_rand = 1'b0; out_rand = 1'b0;
        for (int c = 0; c < 3; c++) woff[c] = 0;

        // R4: negative saturation
        cur_tag = "R4";
        load_table(ONE256, -300 * 65536);
        send(24'hFFFFFF);
        for (int i = 0; i < 15; i++) send(24'($urandom));
        drain();

        // R5: positive saturation and truncation
        cur_tag = "R5";
        load_table(ONE256, 300 * 65536);
        send(24'h000000);
        for (int i = 0; i < 15; i++) send(24'($urandom));
        drain();
        load_table(ONE256, 32768);
        send(24'h7F00FE);
        drain();

        // R7: bypass FIFO full blocks input
        cur_tag = "R7";
        load_table(ONE256, 0);
        warp_hold = 1'b1;
        for (int i = 0; i < DEPTH; i++) send(24'($urandom));
        in_valid = 1'b1;
        in_pixel = 24'hA5C3E1;
        #1;
        chk(!in_ready, "R7", in_ready, 0);
        chk(!warp_req_valid, "R7", warp_req_valid, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(!in_ready && !warp_req_valid, "R7", {in_ready, warp_req_valid}, 0);
        end
        warp_hold = 1'b0;
        @(negedge clk);
        send(24'hA5C3E1);
        drain();

        // R8: full throughput
        cur_tag = "R8";
        first_acc = -1;
        max_streak = 0;
        for (int i = 0; i < 32; i++) send(24'($urandom));
        drain();
        chk(last_acc - first_acc == 31, "R8", last_acc - first_acc, 31);
        chk(max_streak >= 32, "R8", max_streak, 32);

        // R6: ordering under random backpressure on both sides
        cur_tag = "R6";
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 3; c++)
                write_coef(r, c, int'($urandom_range(0, 512 << 16)) - (256 << 16));
        warp_rand = 1'b1; out_rand = 1'b1;
        for (int i = 0; i < 100; i++) send(24'($urandom));
        drain();
        warp_rand = 1'b0; out_rand = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (%s): actual hung expected done", cur_tag);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule